// File: doc/BRIEF.md
# I2C Arbitration-Loss Monitor

This block sits beside an I2C transmitter and watches for the moment the bus disagrees with it. SCL and SDA come in as raw pin levels and are brought into the system clock. On every rising SCL edge that carries a data bit, the monitor compares the bit the transmitter is driving with the SDA level it samples. Any difference means another master won arbitration. The block keeps its own count of SCL clocks within each byte. Software does not need to supply one.

Two update policies can be chosen. In per-bit mode the loss flag follows the latest data-bit comparison. In per-byte mode, any mismatch during the byte is remembered, and the flag is raised only when SCL falls at the end of the ninth clock. The flag then stays up until software clears it. A separate enable makes the monitor release the transmitter's SDA driver in the same cycle the flag rises. The release holds until software clears the flag or the bus shows a stop condition.

Top module: `i2c_arb_monitor`

## Requirements
- R1: After reset, `arb_lost` is 0, `sda_oe_gate` is 1 and `bit_pos` is 0. The synchronised bus levels start at the idle value 1.
- R2: `bit_pos` counts rising SCL edges 1, 2, … 9 within a byte. A rise seen at position 9 returns it to 1. A start condition (SDA falling while SCL stays high) or a stop condition (SDA rising while SCL stays high) sets it to 0.
- R3: A comparison is made only on a rising SCL edge that moves `bit_pos` to 1..8. The rise that moves it to 9 (the acknowledge clock) never affects the flag, whatever `tx_bit` and SDA are.
- R4: With `byte_mode` = 0, each compared rise sets `arb_lost` to 1 if `tx_bit` differs from SDA and to 0 if they agree. At no other time does the flag change, except through a clear.
- R5: With `byte_mode` = 1, a mismatch is held internally. `arb_lost` rises only when SCL falls while `bit_pos` is 9, and only if a mismatch was held. Once set, it stays 1 across later bytes until cleared.
- R6: In per-byte mode the held mismatch is dropped at each ninth-clock fall and at every start or stop condition. A clean byte after such a point leaves `arb_lost` at 0.
- R7: A one-cycle `clr_flag` pulse makes `arb_lost` 0 on the next clock. This holds even when a set would have happened in that same cycle.
- R8: With `stop_en` = 1, `sda_oe_gate` drops to 0 on the same clock edge on which `arb_lost` rises. With `stop_en` = 0 it stays 1.
- R9: Once dropped, `sda_oe_gate` stays 0 even if the per-bit flag falls again. It returns to 1 only on `clr_flag` or a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| tx_bit | input | 1 | Bit the local transmitter drives for the current SCL clock |
| byte_mode | input | 1 | 0: per-bit flag update, 1: sticky per-byte update |
| stop_en | input | 1 | 1: release SDA when arbitration loss is flagged |
| clr_flag | input | 1 | Single-cycle clear of the flag and of the SDA release |
| arb_lost | output | 1 | Arbitration-loss flag |
| sda_oe_gate | output | 1 | 1 lets the transmitter drive SDA, 0 forces high impedance |
| bit_pos | output | $clog2(DATA_BITS+2) | SCL clock position within the byte, 0 when idle |

## Verification
The collision that matters is a software clear landing in the very cycle that a bus event would raise the flag. That event can be a mismatching data-bit rise in per-bit mode or the ninth-clock fall in per-byte mode. The bench counts the synchroniser and edge-detect registers to find the cycle in which that event is being evaluated, and pulses `clr_flag` exactly then. It then requires `arb_lost` to read 0 and `sda_oe_gate` to read 1. Random transactions also drop clears between bytes, and a bench model follows the requirements to judge the outcome.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

   typedef enum logic {
      UPD_BIT  = 1'b0,
      UPD_BYTE = 1'b1
   } upd_mode_e;

   // Bus events derived from synchronised SCL/SDA, one cycle wide each
   typedef struct packed {
      logic rise;
      logic fall;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/i2c_arb_sync.sv
module i2c_arb_sync #(
   parameter int   WIDTH   = 2,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_arb_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("i2c_arb_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= {WIDTH{RST_VAL}};
            else        stage[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage[s] <= {WIDTH{RST_VAL}};
            else        stage[s] <= stage[s-1];
         end
      end
   end

   assign q = stage[STAGES-1];

endmodule

// File: rtl/i2c_arb_events.sv
module i2c_arb_events
   import i2c_arb_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    scl_s,
   input  logic    sda_s,
   output bus_ev_t ev
);

   logic scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   always_comb begin
      ev.rise  = scl_s & ~scl_p;
      ev.fall  = ~scl_s & scl_p;
      ev.start = scl_s & scl_p & ~sda_s & sda_p;
      ev.stop  = scl_s & scl_p & sda_s & ~sda_p;
   end

   // R2
   ev_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ev.rise, ev.fall, ev.start, ev.stop}) <= 1);

endmodule

// File: rtl/i2c_arb_bitpos.sv
module i2c_arb_bitpos
   import i2c_arb_pkg::*;
#(
   parameter int DATA_BITS = 8,
   localparam int LAST     = DATA_BITS + 1,
   localparam int CNT_W    = $clog2(DATA_BITS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  bus_ev_t          ev,
   output logic [CNT_W-1:0] pos,
   output logic             data_rise,
   output logic             last_fall
);

   if (DATA_BITS < 1) begin : g_bad_bits
      $error("i2c_arb_bitpos: DATA_BITS must be at least 1");
   end

   localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(LAST);
   localparam logic [CNT_W-1:0] POS_ACK  = CNT_W'(DATA_BITS);

   logic [CNT_W-1:0] pos_q, pos_d;

   always_comb begin
      pos_d = pos_q;
      if (ev.start || ev.stop) begin
         pos_d = '0;
      end else if (ev.rise) begin
         if (pos_q == POS_LAST) pos_d = CNT_W'(1);
         else                   pos_d = pos_q + CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else        pos_q <= pos_d;
   end

   assign pos       = pos_q;
   // the rise that leads into the acknowledge clock is not compared
   assign data_rise = ev.rise && (pos_q != POS_ACK);
   assign last_fall = ev.fall && (pos_q == POS_LAST);

   // R2
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q <= POS_LAST);

   // R2
   cond_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.start || ev.stop) |=> (pos_q == '0));

   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rise && pos_q == POS_LAST) |=> (pos_q == CNT_W'(1)));

endmodule

// File: rtl/i2c_arb_flag.sv
module i2c_arb_flag
   import i2c_arb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  upd_mode_e mode,
   input  logic      stop_en,
   input  logic      clr,
   input  logic      tx_bit,
   input  logic      sda_s,
   input  logic      data_rise,
   input  logic      last_fall,
   input  bus_ev_t   ev,
   output logic      flag,
   output logic      released
);

   logic flag_q, flag_d;
   logic pend_q, pend_d;
   logic rel_q, rel_d;
   logic mismatch, set_now;

   assign mismatch = data_rise && (tx_bit != sda_s);

   always_comb begin
      flag_d = flag_q;
      pend_d = pend_q;
      if (mode == UPD_BIT) begin
         if (data_rise) flag_d = mismatch;
      end else begin
         if (mismatch) pend_d = 1'b1;
         if (last_fall) begin
            if (pend_q) flag_d = 1'b1;
            pend_d = 1'b0;
         end
      end
      if (ev.start || ev.stop) pend_d = 1'b0;
      if (clr) flag_d = 1'b0;
   end

   assign set_now = flag_d & ~flag_q;

   always_comb begin
      rel_d = rel_q;
      if (clr || ev.stop)         rel_d = 1'b0;
      else if (set_now && stop_en) rel_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         pend_q <= 1'b0;
         rel_q  <= 1'b0;
      end else begin
         flag_q <= flag_d;
         pend_q <= pend_d;
         rel_q  <= rel_d;
      end
   end

   assign flag     = flag_q;
   assign released = rel_q;

   // R7
   clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag_q);

   // R4
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_BIT && !data_rise && !clr) |=> $stable(flag_q));

   // R5
   byte_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_BYTE && !last_fall && !flag_q) |=> !flag_q);

   // R5
   byte_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == UPD_BYTE && flag_q && !clr) |=> flag_q);

   // R9
   rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_q && !clr && !ev.stop) |=> rel_q);

endmodule

// File: rtl/i2c_arb_monitor.sv
module i2c_arb_monitor
   import i2c_arb_pkg::*;
#(
   parameter int DATA_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              scl_in,
   input  logic                              sda_in,
   input  logic                              tx_bit,
   input  logic                              byte_mode,
   input  logic                              stop_en,
   input  logic                              clr_flag,
   output logic                              arb_lost,
   output logic                              sda_oe_gate,
   output logic [$clog2(DATA_BITS+2)-1:0]    bit_pos
);

   localparam int CNT_W = $clog2(DATA_BITS + 2);

   logic [1:0]       bus_s;
   bus_ev_t          ev;
   logic [CNT_W-1:0] pos;
   logic             data_rise, last_fall;
   logic             flag, released;
   upd_mode_e        mode;

   assign mode = upd_mode_e'(byte_mode);

   i2c_arb_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_in, sda_in}),
      .q     (bus_s)
   );

   i2c_arb_events u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_s (bus_s[1]),
      .sda_s (bus_s[0]),
      .ev    (ev)
   );

   i2c_arb_bitpos #(
      .DATA_BITS (DATA_BITS)
   ) u_bitpos (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .pos       (pos),
      .data_rise (data_rise),
      .last_fall (last_fall)
   );

   i2c_arb_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .stop_en   (stop_en),
      .clr       (clr_flag),
      .tx_bit    (tx_bit),
      .sda_s     (bus_s[0]),
      .data_rise (data_rise),
      .last_fall (last_fall),
      .ev        (ev),
      .flag      (flag),
      .released  (released)
   );

   assign arb_lost    = flag;
   assign sda_oe_gate = ~released;
   assign bit_pos     = pos;

   // R8
   gate_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(arb_lost) && $past(stop_en)) |-> !sda_oe_gate);

   // R8
   gate_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe_gate) |-> ($rose(arb_lost) && $past(stop_en)));

   // R3
   ack_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_mode && ev.rise && pos == CNT_W'(DATA_BITS) && !clr_flag) |=> $stable(arb_lost));

endmodule

// File: tb/test_i2c_arb_monitor.sv
`timescale 1ns/1ps
module test_i2c_arb_monitor;

   localparam int SET = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1, sda_in = 1'b1, tx_bit = 1'b1;
   logic       byte_mode = 1'b0, stop_en = 1'b0, clr_flag = 1'b0;
   logic       arb_lost, sda_oe_gate;
   logic [3:0] bit_pos;

   int n_checks = 0;
   int n_err = 0;
   bit done = 0;

   // model state, driven by the requirements
   int exp_flag = 0, exp_pend = 0, exp_rel = 0, exp_pos = 0;

   always #2 clk = ~clk;

   i2c_arb_monitor i_i2c_arb_monitor (
      .clk (clk), .rst_n (rst_n), .scl_in (scl_in), .sda_in (sda_in),
      .tx_bit (tx_bit), .byte_mode (byte_mode), .stop_en (stop_en),
      .clr_flag (clr_flag), .arb_lost (arb_lost), .sda_oe_gate (sda_oe_gate),
      .bit_pos (bit_pos)
   );

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic void raise_flag(int v);
      if (exp_flag == 0 && v == 1 && stop_en) exp_rel = 1;
      exp_flag = v;
   endfunction

   function automatic void m_rise(int t, int s);
      if (exp_pos != 8) begin
         if (!byte_mode) raise_flag((t != s) ? 1 : 0);
         else if (t != s) exp_pend = 1;
      end
      exp_pos = (exp_pos == 9) ? 1 : exp_pos + 1;
   endfunction

   function automatic void m_fall();
      if (exp_pos == 9 && byte_mode) begin
         if (exp_pend == 1) raise_flag(1);
         exp_pend = 0;
      end
   endfunction

   function automatic void m_clear();
      exp_flag = 0;
      exp_rel = 0;
   endfunction

   task automatic settle();
      repeat (SET) @(negedge clk);
   endtask

   task automatic check_all(string ftag, string gtag);
      check(ftag, int'(arb_lost), exp_flag);
      check(gtag, int'(sda_oe_gate), (exp_rel == 0) ? 1 : 0);
      check("R2", int'(bit_pos), exp_pos);
   endtask

   task automatic put_bit(logic t, logic s);
      tx_bit = t; sda_in = s; settle();
      scl_in = 1'b1; m_rise(t, s); settle();
      scl_in = 1'b0; m_fall(); settle();
   endtask

   task automatic do_start();
      sda_in = 1'b0; exp_pos = 0; exp_pend = 0; settle();
      scl_in = 1'b0; settle();
   endtask

   task automatic do_stop();
      tx_bit = 1'b0; sda_in = 1'b0; settle();
      scl_in = 1'b1; m_rise(0, 0); settle();
      sda_in = 1'b1; exp_pos = 0; exp_pend = 0; exp_rel = 0; settle();
   endtask

   task automatic pulse_clr();
      clr_flag = 1'b1; @(negedge clk);
      clr_flag = 1'b0; m_clear(); settle();
   endtask

   task automatic send_byte(logic [7:0] tx, logic [7:0] other, logic ackv);
      for (int i = 7; i >= 0; i--) begin
         put_bit(tx[i], tx[i] & other[i]);
         check_all(byte_mode ? "R5" : "R4", "R8");
      end
      put_bit(1'b1, ackv);
      check_all("R3", "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   initial begin
      logic [7:0] tx, oth;
      int nb;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      // R1 reset state
      check("R1", int'(arb_lost), 0);
      check("R1", int'(sda_oe_gate), 1);
      check("R1", int'(bit_pos), 0);

      // R8/R9 per-bit mode with release
      byte_mode = 1'b0; stop_en = 1'b1; settle();
      do_start();
      check("R2", int'(bit_pos), 0);
      put_bit(1'b1, 1'b1); put_bit(1'b1, 1'b0);
      check("R4", int'(arb_lost), 1);
      check("R8", int'(sda_oe_gate), 0);
      put_bit(1'b0, 1'b0);
      check("R4", int'(arb_lost), 0);
      check("R9", int'(sda_oe_gate), 0);
      for (int i = 0; i < 5; i++) put_bit(1'b0, 1'b0);
      put_bit(1'b1, 1'b0);   // ack clock, mismatched levels
      check("R3", int'(arb_lost), 0);
      check("R2", int'(bit_pos), 9);
      put_bit(1'b0, 1'b0);
      check("R2", int'(bit_pos), 1);
      do_stop();
      check("R9", int'(sda_oe_gate), 1);
      check("R2", int'(bit_pos), 0);

      // R8 with stop_en low, R9 clear releases
      stop_en = 1'b0; settle();
      do_start();
      put_bit(1'b1, 1'b0);
      check("R8", int'(sda_oe_gate), 1);
      check("R4", int'(arb_lost), 1);
      pulse_clr();
      check("R7", int'(arb_lost), 0);
      do_stop();

      // R5/R6 per-byte mode
      byte_mode = 1'b1; stop_en = 1'b1; settle();
      do_start();
      send_byte(8'hF0, 8'hBF, 1'b0);
      check("R5", int'(arb_lost), 1);
      check("R8", int'(sda_oe_gate), 0);
      send_byte(8'h3C, 8'hFF, 1'b0);
      check("R5", int'(arb_lost), 1);
      pulse_clr();
      check("R9", int'(sda_oe_gate), 1);
      send_byte(8'h55, 8'hFF, 1'b0);
      check("R6", int'(arb_lost), 0);
      do_stop();
      // R6 partial byte with mismatch, then stop and restart
      do_start();
      put_bit(1'b1, 1'b0); put_bit(1'b0, 1'b0);
      check("R5", int'(arb_lost), 0);
      do_stop();
      do_start();
      send_byte(8'hA5, 8'hFF, 1'b1);
      check("R6", int'(arb_lost), 0);
      do_stop();

      // R7 collision: clear in the cycle of the ninth-clock fall
      do_start();
      for (int i = 0; i < 8; i++) put_bit(1'b1, (i == 2) ? 1'b0 : 1'b1);
      tx_bit = 1'b1; sda_in = 1'b0; settle();
      scl_in = 1'b1; m_rise(1, 0); settle();
      scl_in = 1'b0;
      @(negedge clk); @(negedge clk);
      clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
      m_fall(); m_clear(); settle();
      check("R7", int'(arb_lost), 0);
      check("R7", int'(sda_oe_gate), 1);
      do_stop();

      // R7 collision: clear in the cycle of a mismatching per-bit rise
      byte_mode = 1'b0; settle();
      do_start();
      tx_bit = 1'b1; sda_in = 1'b0; settle();
      scl_in = 1'b1;
      @(negedge clk); @(negedge clk);
      clr_flag = 1'b1; @(negedge clk); clr_flag = 1'b0;
      m_rise(1, 0); m_clear(); settle();
      check("R7", int'(arb_lost), 0);
      check("R7", int'(sda_oe_gate), 1);
      scl_in = 1'b0; m_fall(); settle();
      do_stop();

      // random transactions
      for (int t = 0; t < 40; t++) begin
         byte_mode = 1'($urandom % 2);
         stop_en   = 1'($urandom % 2);
         settle();
         do_start();
         nb = 1 + int'($urandom % 2);
         for (int b = 0; b < nb; b++) begin
            tx  = 8'($urandom);
            oth = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
            send_byte(tx, oth, 1'($urandom % 2));
            if ($urandom % 3 == 0) pulse_clr();
         end
         do_stop();
         check_all(byte_mode ? "R5" : "R4", "R9");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule